// File: doc/BRIEF.md
# Boost Converter Start-Up and Fault-Recovery Sequencer

This block decides when a peak-current-mode boost controller may switch its power transistor, and what soft-start reference code it hands to the reference DAC. It takes digital comparator flags as inputs. The input-supply and die-temperature monitors each give a pair of flags, one for the trip level and one for the release level, and the sequencer builds the hysteresis band from the two. It also takes a hard overcurrent flag, which sits above the cycle-by-cycle limit, a feedback-too-low flag, an enable level and a one-clock pulse once per switching period.

A start begins with a fixed delay counted in system clocks. Switching is then enabled and the reference code climbs one step per switching period, from zero to full scale. The code rises faster when the switching frequency is raised. Short detection stays masked for a blanking window measured from the first soft-start step. It is honoured only when the short-protection configuration input is high. An overcurrent or a short after blanking stops switching and starts a hiccup off-period. When the off-period ends, a fresh soft-start begins without the start delay. Loss of enable, an input undervoltage or an over-temperature forces the block back to idle from any state, and the next start again runs the delay.

All windows tied to the soft-start length are whole switching periods, derived from the step count by rounding a percentage down. There is no data stream here: every pin is a plain level or pulse, so there is no back-pressure to honour.

Top module: `boost_ss_sequencer`

## Requirements
- R1: While `rst_n` is low and right after its release, `sw_en` is 0 and `ss_code` is 0.
- R2: A start needs `enable` high with both monitors released. `sw_en` goes high exactly DELAY_CLKS+1 clock edges after `enable` is raised into an otherwise ready block. It goes high DELAY_CLKS+2 edges after the last monitor release flag is raised with `enable` already high. Dropping `enable` during the delay restarts the delay from zero.
- R3: Supply hysteresis. `vin_below_fall`=1 stops switching within 2 edges. With both supply flags low, the state does not change. Switching resumes only after `vin_above_rise`=1.
- R4: Thermal hysteresis. `tj_above_trip`=1 stops switching within 2 edges. With both thermal flags low, the state does not change. A restart needs `tj_below_release`=1.
- R5: During soft-start, `ss_code` rises by exactly 1 on each edge where `sw_tick`=1 and holds otherwise. It stops at SS_STEPS, which also ends soft-start. It stays at SS_STEPS while running.
- R6: `oc_flag`=1 while switching drops `sw_en` and clears `ss_code` to 0 on the next edge, during soft-start or run.
- R7: The hiccup off-period lasts HICCUP_CYC = floor(SS_STEPS*HICCUP_PCT/100) ticks. On the last of them, soft-start restarts from code 0 with no start delay.
- R8: Short detection is masked until BLANK_CYC = floor(SS_STEPS*BLANK_PCT/100) ticks have occurred since soft-start began. A held `fb_low` trips on the edge after the BLANK_CYC-th tick.
- R9: With `short_en`=0, `fb_low` has no effect on `sw_en` or `ss_code`.
- R10: With `short_en`=1 and blanking over, `fb_low`=1 stops switching on the next edge and enters hiccup.
- R11: Loss of `enable` forces idle from any state, including hiccup. No hiccup-end restart follows, and the next start runs the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable level |
| vin_above_rise | input | 1 | Input supply above the release level (threshold plus hysteresis) |
| vin_below_fall | input | 1 | Input supply below the lockout threshold |
| tj_above_trip | input | 1 | Die temperature above the shutdown level |
| tj_below_release | input | 1 | Die temperature below the restart level |
| oc_flag | input | 1 | Hard overcurrent comparator output |
| fb_low | input | 1 | Feedback below the short-circuit fraction of the reference |
| short_en | input | 1 | Configuration: short protection active when 1 |
| sw_tick | input | 1 | One-clock pulse per switching period |
| sw_en | output | 1 | Gate switching allowed |
| ss_code | output | CODE_W | Soft-start reference code, 0 to SS_STEPS |

## Verification
The bench holds the feedback flag low from the first soft-start step. It expects the trip on exactly the edge after the last blanking tick. A design that counts the window from enable, or ends it with the ramp, trips early, and one with an off-by-one window trips a tick late. The hiccup is counted tick by tick, and the restart must show code 0 with switching on. A design that re-runs the start delay, or resumes the old code, fails here. The monitors are left sitting in their hysteresis band in both directions. This exposes a design that treats a release flag falling as a fault, or that restarts without a release. The stimulus table mixes overcurrent, low feedback and the configuration bit, so a design that ignores the configuration bit, or lets overcurrent depend on it, is caught.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_DELAY  = 3'd1,
    ST_SOFT   = 3'd2,
    ST_RUN    = 3'd3,
    ST_HICCUP = 3'd4
  } ssq_state_e;

  // Whole switching periods for a percentage of the soft-start length.
  function automatic int scale_pct(input int base, input int pct);
    return (base * pct) / 100;
  endfunction

  function automatic logic is_switching(input ssq_state_e s);
    return (s == ST_SOFT) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/ssq_hyst_latch.sv
// Two-level hysteresis: trip clears ok (wins), arm sets it, neither holds.
module ssq_hyst_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic trip_i,
  output logic ok_o
);

  logic ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ok_q <= 1'b0;
    else if (trip_i) ok_q <= 1'b0;
    else if (arm_i)  ok_q <= 1'b1;
  end

  assign ok_o = ok_q;

  AST_TRIP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> !ok_o); // R3

  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_i && !arm_i) |=> $stable(ok_o)); // R4

endmodule

// File: rtl/ssq_ramp.sv
// Soft-start code ramp and short-detection blanking counter.
module ssq_ramp #(
  parameter int STEPS     = 64,
  parameter int BLANK_CYC = 76,
  parameter int CODE_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep_i,     // next state is a switching state
  input  logic              adv_i,      // currently in soft-start
  input  logic              active_i,   // currently switching
  input  logic              tick_i,
  input  logic              short_en_i,
  input  logic              fb_low_i,
  output logic [CODE_W-1:0] code_o,
  output logic              full_o,
  output logic              short_trip_o
);

  localparam int BLK_W = $clog2(BLANK_CYC + 1);

  logic [CODE_W-1:0] code_q;
  logic [BLK_W-1:0]  blank_q;
  logic              armed;

  assign full_o = (code_q == CODE_W'(STEPS));
  assign armed  = (blank_q == BLK_W'(BLANK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (!keep_i) begin
      code_q <= '0;
    end else if (adv_i && tick_i && !full_o) begin
      code_q <= code_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
    end else if (!keep_i) begin
      blank_q <= '0;
    end else if (active_i && tick_i && !armed) begin
      blank_q <= blank_q + 1'b1;
    end
  end

  assign short_trip_o = active_i && short_en_i && armed && fb_low_i;
  assign code_o       = code_q;

  AST_CODE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    code_o <= CODE_W'(STEPS)); // R5

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_i && !tick_i) |=> $stable(code_o)); // R5

  AST_NO_TRIP_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
    !short_en_i |-> !short_trip_o); // R9

endmodule

// File: rtl/ssq_fsm.sv
// Sequencing state machine with start-delay and hiccup counters.
module ssq_fsm
  import ssq_pkg::*;
#(
  parameter int DELAY_CLKS = 2000,
  parameter int HICCUP_CYC = 54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_ok_i,
  input  logic       tick_i,
  input  logic       fault_i,
  input  logic       ramp_full_i,
  output ssq_state_e state_o,
  output logic       keep_o,
  output logic       adv_o,
  output logic       sw_en_o
);

  localparam int DLY_W = $clog2(DELAY_CLKS + 1);
  localparam int HIC_W = $clog2(HICCUP_CYC + 1);

  ssq_state_e       state_q, state_d;
  logic [DLY_W-1:0] dly_q;
  logic [HIC_W-1:0] hic_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:    state_d = ST_DELAY;
      ST_DELAY:  if (dly_q == DLY_W'(DELAY_CLKS - 1)) state_d = ST_SOFT;
      ST_SOFT: begin
        if (fault_i)          state_d = ST_HICCUP;
        else if (ramp_full_i) state_d = ST_RUN;
      end
      ST_RUN:    if (fault_i) state_d = ST_HICCUP;
      ST_HICCUP: if (tick_i && hic_q == HIC_W'(HICCUP_CYC - 1)) state_d = ST_SOFT;
      default:   state_d = ST_OFF;
    endcase
    if (!en_ok_i) state_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      dly_q   <= '0;
      hic_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DELAY && state_d == ST_DELAY) dly_q <= dly_q + 1'b1;
      else                                            dly_q <= '0;
      if (state_q != ST_HICCUP || state_d != ST_HICCUP) hic_q <= '0;
      else if (tick_i)                                  hic_q <= hic_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign sw_en_o = is_switching(state_q);
  assign keep_o  = is_switching(state_d);
  assign adv_o   = (state_q == ST_SOFT);

  AST_OFF_NEVER_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> !sw_en_o); // R2

  AST_HICCUP_LEAVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HICCUP && !tick_i && en_ok_i) |=> (state_q == ST_HICCUP)); // R7

  AST_HICCUP_TO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_HICCUP && sw_en_o) |-> (state_q == ST_SOFT)); // R7

endmodule

// File: rtl/boost_ss_sequencer.sv
module boost_ss_sequencer
  import ssq_pkg::*;
#(
  parameter int SS_STEPS    = 64,
  parameter int BLANK_PCT   = 120,
  parameter int HICCUP_PCT  = 85,
  parameter int DELAY_CLKS  = 2000,
  parameter int CODE_W      = $clog2(SS_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              vin_above_rise,
  input  logic              vin_below_fall,
  input  logic              tj_above_trip,
  input  logic              tj_below_release,
  input  logic              oc_flag,
  input  logic              fb_low,
  input  logic              short_en,
  input  logic              sw_tick,
  output logic              sw_en,
  output logic [CODE_W-1:0] ss_code
);

  localparam int BLANK_CYC  = scale_pct(SS_STEPS, BLANK_PCT);
  localparam int HICCUP_CYC = scale_pct(SS_STEPS, HICCUP_PCT);
  localparam int N_MON      = 2;   // 0: input supply, 1: die temperature

  logic [N_MON-1:0] mon_arm, mon_trip, mon_ok;
  logic             en_ok, keep, adv, ramp_full, short_trip, fault;
  ssq_state_e       state;

  assign mon_arm  = {tj_below_release, vin_above_rise};
  assign mon_trip = {tj_above_trip,    vin_below_fall};

  for (genvar g = 0; g < N_MON; g++) begin : g_mon
    ssq_hyst_latch u_hyst (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (mon_arm[g]),
      .trip_i (mon_trip[g]),
      .ok_o   (mon_ok[g])
    );
  end

  assign en_ok = enable && (&mon_ok);
  assign fault = oc_flag || short_trip;

  ssq_fsm #(
    .DELAY_CLKS (DELAY_CLKS),
    .HICCUP_CYC (HICCUP_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_ok_i     (en_ok),
    .tick_i      (sw_tick),
    .fault_i     (fault),
    .ramp_full_i (ramp_full),
    .state_o     (state),
    .keep_o      (keep),
    .adv_o       (adv),
    .sw_en_o     (sw_en)
  );

  ssq_ramp #(
    .STEPS     (SS_STEPS),
    .BLANK_CYC (BLANK_CYC),
    .CODE_W    (CODE_W)
  ) u_ramp (
    .clk          (clk),
    .rst_n        (rst_n),
    .keep_i       (keep),
    .adv_i        (adv),
    .active_i     (sw_en),
    .tick_i       (sw_tick),
    .short_en_i   (short_en),
    .fb_low_i     (fb_low),
    .code_o       (ss_code),
    .full_o       (ramp_full),
    .short_trip_o (short_trip)
  );

  AST_OC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && oc_flag) |=> (!sw_en && ss_code == '0)); // R6

  AST_SUPPLY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_ok[0] |=> !sw_en); // R3

  AST_THERMAL_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_ok[1] |=> !sw_en); // R4

  AST_ENABLE_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sw_en && state == ST_OFF)); // R11

  AST_START_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_en) && en_ok && !oc_flag) |=> sw_en); // R8

  AST_CODE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |=> (!sw_en || ss_code >= $past(ss_code))); // R5

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (ss_code == '0)); // R1

endmodule

// File: tb/sim_boost_ss_sequencer.sv
module sim_boost_ss_sequencer;

  localparam int SS      = 8;
  localparam int DLY     = 10;
  localparam int BLANK_T = (SS * 120) / 100;  // 9
  localparam int HIC_T   = (SS * 85) / 100;   // 6
  localparam int CW      = $clog2(SS + 1);

  // {oc_flag, fb_low, short_en, expect_trip}
  localparam logic [3:0] VEC [0:5] = '{4'b0010, 4'b0111, 4'b0100,
                                       4'b1001, 4'b1111, 4'b0000};

  logic clk = 1'b0;
  logic rst_n, enable, vin_above_rise, vin_below_fall;
  logic tj_above_trip, tj_below_release, oc_flag, fb_low, short_en, sw_tick;
  logic sw_en;
  logic [CW-1:0] ss_code;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  boost_ss_sequencer #(
    .SS_STEPS   (SS),
    .BLANK_PCT  (120),
    .HICCUP_PCT (85),
    .DELAY_CLKS (DLY)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .vin_above_rise(vin_above_rise), .vin_below_fall(vin_below_fall),
    .tj_above_trip(tj_above_trip), .tj_below_release(tj_below_release),
    .oc_flag(oc_flag), .fb_low(fb_low), .short_en(short_en),
    .sw_tick(sw_tick), .sw_en(sw_en), .ss_code(ss_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One tick edge; returns at the negedge right after it.
  task automatic tick_now();
    sw_tick = 1'b1;
    @(negedge clk);
    sw_tick = 1'b0;
  endtask

  task automatic tick_idle();
    tick_now();
    idle(2);
  endtask

  task automatic edges_to_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sw_en && n < 200);
  endtask

  // From the start of soft-start: ramp fully and clear blanking.
  task automatic run_to_armed();
    for (int i = 0; i < BLANK_T; i++) tick_idle();
    check("R5 full code after ramp", ss_code, SS);
    check("R5 running", sw_en, 1);
  endtask

  task automatic hiccup_through();
    for (int j = 1; j < HIC_T; j++) begin
      tick_idle();
      check("R7 off during hiccup", sw_en, 0);
    end
    tick_now();
    check("R7 restart without delay", sw_en, 1);
    check("R7 restart code zero", ss_code, 0);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; enable = 1'b0; vin_above_rise = 1'b0; vin_below_fall = 1'b0;
    tj_above_trip = 1'b0; tj_below_release = 1'b0; oc_flag = 1'b0;
    fb_low = 1'b0; short_en = 1'b0; sw_tick = 1'b0;
    idle(3);
    check("R1 reset sw_en", sw_en, 0);
    check("R1 reset code", ss_code, 0);
    rst_n = 1'b1;
    idle(1);
    check("R1 after release", sw_en, 0);

    // R2: enable alone does not start
    enable = 1'b1;
    idle(30);
    check("R2 no start while locked out", sw_en, 0);
    vin_above_rise = 1'b1; tj_below_release = 1'b1;
    edges_to_start(n);
    check("R2 start delay via monitors", n, DLY + 2);
    check("R5 code at start", ss_code, 0);

    // R5, R8, R10: ramp with feedback held low from the first step
    short_en = 1'b1; fb_low = 1'b1;
    for (int i = 1; i <= BLANK_T; i++) begin
      tick_now();
      check("R8 masked during blanking", sw_en, 1);
      check("R5 code per tick", ss_code, (i < SS) ? i : SS);
      if (i < BLANK_T) begin
        idle(2);
        check("R5 code holds between ticks", ss_code, (i < SS) ? i : SS);
      end
    end
    idle(1);
    check("R10 short trips after blanking", sw_en, 0);
    check("R10 code cleared", ss_code, 0);
    fb_low = 1'b0;
    hiccup_through();
    run_to_armed();

    // Stimulus table walked in RUN with blanking over
    for (int k = 0; k < 6; k++) begin
      short_en = VEC[k][1];
      oc_flag  = VEC[k][3];
      fb_low   = VEC[k][2];
      @(negedge clk);
      oc_flag = 1'b0; fb_low = 1'b0;
      check("R6/R9/R10 table sw_en", sw_en, VEC[k][0] ? 0 : 1);
      check("R6/R9 table code", ss_code, VEC[k][0] ? 0 : SS);
      if (VEC[k][0]) begin
        hiccup_through();
        run_to_armed();
      end else begin
        idle(3);
        check("R9 no late effect", sw_en, 1);
      end
    end

    // R3: supply hysteresis
    vin_above_rise = 1'b0;
    idle(5);
    check("R3 band keeps running", sw_en, 1);
    vin_below_fall = 1'b1;
    @(negedge clk);
    vin_below_fall = 1'b0;
    @(negedge clk);
    check("R3 lockout stops", sw_en, 0);
    check("R3 lockout code", ss_code, 0);
    idle(30);
    check("R3 band keeps off", sw_en, 0);
    vin_above_rise = 1'b1;
    edges_to_start(n);
    check("R3 release restarts with delay", n, DLY + 2);

    // R4: thermal hysteresis
    tj_below_release = 1'b0;
    idle(5);
    check("R4 band keeps running", sw_en, 1);
    tj_above_trip = 1'b1;
    @(negedge clk);
    tj_above_trip = 1'b0;
    @(negedge clk);
    check("R4 over-temperature stops", sw_en, 0);
    idle(30);
    check("R4 band keeps off", sw_en, 0);
    tj_below_release = 1'b1;
    edges_to_start(n);
    check("R4 cool restart with delay", n, DLY + 2);

    // R6: overcurrent mid-ramp
    for (int i = 0; i < 3; i++) tick_idle();
    check("R5 partial ramp", ss_code, 3);
    oc_flag = 1'b1;
    @(negedge clk);
    oc_flag = 1'b0;
    check("R6 overcurrent in soft-start", sw_en, 0);
    check("R6 code cleared", ss_code, 0);

    // R11: enable loss during hiccup
    tick_idle();
    enable = 1'b0;
    for (int j = 0; j < HIC_T + 2; j++) tick_idle();
    check("R11 no restart after enable loss", sw_en, 0);
    enable = 1'b1;
    edges_to_start(n);
    check("R11 full delay after re-enable", n, DLY + 1);

    // R2: enable glitch during the delay restarts it
    enable = 1'b0;
    idle(2);
    enable = 1'b1;
    idle(4);
    check("R2 still in delay", sw_en, 0);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    edges_to_start(n);
    check("R2 delay restarted", n, DLY + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule